// File: doc/BRIEF.md
# DRAM Page-Mode Access Sequencer

This block sequences single accesses from a simple bus controller onto a DRAM with a multiplexed row/column address. It drives an active-low row strobe, separate upper and lower column strobes, a write strobe and an output enable. Requests that target a non-DRAM space go through the same sequencer. They drive a chip-select for that space and no DRAM strobe. Each request is a one-cycle pulse that the block takes while it is idle. The block flags the final state of the access with a one-cycle done pulse.

A full DRAM access runs through a precharge state, a row state and two column states. A configuration bit adds a third column state. Wait states fall between the first and second column states. With burst enabled, the block keeps the row open after a DRAM access, and a later access to the same row runs only the column states. When burst and row-hold are both enabled, the row also stays open across accesses to other spaces. A row hit after such an interruption still goes straight to the column states. A DRAM access to a different row releases the row strobe, precharges and opens the new row.

Top module: `dram_page_seq`

## Requirements
- R1: After reset, ras_n, ucas_n, lcas_n, we_n, oe_n and oth_cs_n are 1 and busy is 0.
- R2: A DRAM access with no open row takes the states precharge, row, column-1 and column-2, plus column-3 when cfg_cas_ext=1. That is 4 or 5 states without waits, with acc_done high in the final state. ras_n is high in the precharge state and low from the row state on.
- R3: cfg_wait (sampled when the request is taken) inserts that many wait states between column-1 and column-2. This applies equally to full accesses and to row-hit accesses.
- R4: With cfg_burst_en=1, a DRAM access to the row left open by the previous DRAM access runs only the column states (2 + ext + waits), and ras_n stays low throughout.
- R5: A DRAM access to a row other than the open one releases ras_n in a precharge state and then opens the new row. It takes the same number of states as R2.
- R6: With cfg_burst_en=0, ras_n returns high after every DRAM access, and each DRAM access is a full access.
- R7: With cfg_burst_en=1 and cfg_ras_down=1, ras_n stays low through an access to another space that follows a DRAM access. The next DRAM access to the same row is then a row hit.
- R8: With cfg_burst_en=1 and cfg_ras_down=0, an access to another space releases ras_n for its whole duration, and the next DRAM access is a full access.
- R9: Column strobes are low in wait states and in column-2/3 only: ucas_n for req_be[1]=1 and lcas_n for req_be[0]=1. mem_addr carries the column (req_addr low COL_W bits) then, and carries the row (req_addr high ROW_W bits) in precharge and row states.
- R10: In the column and wait states of a read (req_write=0), oe_n is low and we_n stays high. For a write the two are swapped.
- R11: An access to another space (req_dram=0) holds oth_cs_n low for 2 + cfg_wait states and keeps all column, write and output-enable strobes high.
- R12: Clearing cfg_burst_en while idle closes the open row: ras_n goes high and the next DRAM access is a full access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pulse, taken when busy is 0 |
| req_dram | input | 1 | 1 = DRAM space, 0 = other space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 1 upper, bit 0 lower |
| req_addr | input | ROW_W+COL_W | Row in upper bits, column in lower bits |
| cfg_burst_en | input | 1 | Burst (page) enable |
| cfg_ras_down | input | 1 | Hold row across other-space accesses (with burst) |
| cfg_cas_ext | input | 1 | Add a third column state |
| cfg_wait | input | WAIT_W | Wait states per access |
| busy | output | 1 | Access in progress |
| acc_done | output | 1 | Final state of the access |
| mem_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| ucas_n | output | 1 | Upper column strobe, active low |
| lcas_n | output | 1 | Lower column strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| oe_n | output | 1 | Output enable, active low |
| oth_cs_n | output | 1 | Other-space select, active low |

## Verification
The bench targets row-hit and row-miss sequences before and after interruptions by other spaces, with and without the hold mode, and with waits and the third column state mixed in. A design that forgets the open row would take four states where two are due. One that matches a stale row would skip the precharge and read the wrong page. The bench watches the row strobe during each other-space access, because a design that releases it in hold mode, or keeps it low in plain burst mode, breaks R7 or R8. It also disables burst while idle and expects the row strobe to rise, which catches an open-row flag that outlives its mode.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_TP, S_TR, S_TC1, S_TW, S_TC2, S_TC3, S_OT1, S_OTW, S_OT2
  } dseq_state_e;
endpackage

// File: rtl/dseq_wait_ctr.sv
module dseq_wait_ctr #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         cnt_zero,
  output logic         cnt_last
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load || dec) cnt_q <= cnt_d;
  end

  assign cnt_zero = (cnt_q == '0);
  assign cnt_last = (cnt_q == W'(1));

  AST_WAIT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> !cnt_zero); // R3
endmodule

// File: rtl/dseq_row_tracker.sv
module dseq_row_tracker #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             clear,
  input  logic             set,
  input  logic [ROW_W-1:0] set_row,
  input  logic [ROW_W-1:0] look_row,
  output logic             vld,
  output logic             hit
);
  logic             vld_q, vld_d;
  logic [ROW_W-1:0] row_q;

  always_comb begin
    vld_d = vld_q;
    if (flush)      vld_d = 1'b0;
    else if (set)   vld_d = 1'b1;
    else if (clear) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   row_q <= '0;
    else if (set) row_q <= set_row;
  end

  assign vld = vld_q;
  assign hit = vld_q && (row_q == look_row);

  AST_FLUSH_CLOSES_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !vld); // R12
endmodule

// File: rtl/dseq_strobe_dec.sv
module dseq_strobe_dec
  import dram_seq_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int COL_W = 8,
  parameter int MA_W  = 8
) (
  input  dseq_state_e      state,
  input  logic             row_open,
  input  logic [1:0]       be,
  input  logic             write,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  output logic [MA_W-1:0]  mem_addr,
  output logic             ras_n,
  output logic             ucas_n,
  output logic             lcas_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             oth_cs_n
);
  logic in_row, in_col, cas_on, in_oth;

  always_comb begin
    in_row = state inside {S_TR, S_TC1, S_TW, S_TC2, S_TC3};
    in_col = state inside {S_TC1, S_TW, S_TC2, S_TC3};
    cas_on = state inside {S_TW, S_TC2, S_TC3};
    in_oth = state inside {S_OT1, S_OTW, S_OT2};
    ras_n    = !(row_open || in_row);
    ucas_n   = !(cas_on && be[1]);
    lcas_n   = !(cas_on && be[0]);
    we_n     = !(in_col && write);
    oe_n     = !(in_col && !write);
    oth_cs_n = !in_oth;
    if (state inside {S_TP, S_TR}) mem_addr = MA_W'(row);
    else if (in_col)               mem_addr = MA_W'(col);
    else                           mem_addr = '0;
  end
endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq
  import dram_seq_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 8,
  parameter int WAIT_W = 3,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_dram,
  input  logic              req_write,
  input  logic [1:0]        req_be,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              cfg_burst_en,
  input  logic              cfg_ras_down,
  input  logic              cfg_cas_ext,
  input  logic [WAIT_W-1:0] cfg_wait,
  output logic              busy,
  output logic              acc_done,
  output logic [MA_W-1:0]   mem_addr,
  output logic              ras_n,
  output logic              ucas_n,
  output logic              lcas_n,
  output logic              we_n,
  output logic              oe_n,
  output logic              oth_cs_n
);
  dseq_state_e      state_q, state_d;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [1:0]       be_q;
  logic             wr_q, ext_q;
  logic             accept, rd_mode, row_vld, row_hit;
  logic             w_zero, w_last, w_dec;
  logic [ROW_W-1:0] req_row;

  assign req_row = req_addr[ADDR_W-1:COL_W];
  assign accept  = (state_q == S_IDLE) && req_valid;
  assign rd_mode = cfg_burst_en && cfg_ras_down;
  assign w_dec   = state_q inside {S_TW, S_OTW};

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (req_valid) state_d = !req_dram ? S_OT1 : (row_hit ? S_TC1 : S_TP);
      S_TP:   state_d = S_TR;
      S_TR:   state_d = S_TC1;
      S_TC1:  state_d = w_zero ? S_TC2 : S_TW;
      S_TW:   if (w_last) state_d = S_TC2;
      S_TC2:  state_d = ext_q ? S_TC3 : S_IDLE;
      S_TC3:  state_d = S_IDLE;
      S_OT1:  state_d = w_zero ? S_OT2 : S_OTW;
      S_OTW:  if (w_last) state_d = S_OT2;
      S_OT2:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
      be_q  <= '0;
      wr_q  <= 1'b0;
      ext_q <= 1'b0;
    end else if (accept) begin
      row_q <= req_row;
      col_q <= req_addr[COL_W-1:0];
      be_q  <= req_be;
      wr_q  <= req_write;
      ext_q <= cfg_cas_ext;
    end
  end

  assign acc_done = ((state_q == S_TC2) && !ext_q) || (state_q == S_TC3) ||
                    (state_q == S_OT2);
  assign busy     = (state_q != S_IDLE);

  dseq_wait_ctr #(.W(WAIT_W)) i_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (cfg_wait),
    .dec      (w_dec),
    .cnt_zero (w_zero),
    .cnt_last (w_last)
  );

  dseq_row_tracker #(.ROW_W(ROW_W)) i_rows (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (!cfg_burst_en),
    .clear    (accept && (req_dram ? !row_hit : !rd_mode)),
    .set      (acc_done && (state_q inside {S_TC2, S_TC3})),
    .set_row  (row_q),
    .look_row (req_row),
    .vld      (row_vld),
    .hit      (row_hit)
  );

  dseq_strobe_dec #(.ROW_W(ROW_W), .COL_W(COL_W), .MA_W(MA_W)) i_dec (
    .state    (state_q),
    .row_open (row_vld),
    .be       (be_q),
    .write    (wr_q),
    .row      (row_q),
    .col      (col_q),
    .mem_addr (mem_addr),
    .ras_n    (ras_n),
    .ucas_n   (ucas_n),
    .lcas_n   (lcas_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .oth_cs_n (oth_cs_n)
  );

  AST_TP_RAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_TP) |-> ras_n); // R5
  AST_CAS_NEEDS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ucas_n || !lcas_n) |-> !ras_n); // R9
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n)); // R10
  AST_OTH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !oth_cs_n |-> (ucas_n && lcas_n && we_n && oe_n)); // R11
  AST_RAS_HELD_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q inside {S_OTW, S_OT2}) && cfg_burst_en && $past(cfg_burst_en))
      |-> $stable(ras_n)); // R7
  AST_IDLE_NOBURST_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_IDLE) && !cfg_burst_en) |=> ras_n); // R6
endmodule

// File: tb/test_dram_page_seq.sv
module test_dram_page_seq;
  localparam int ROW_W = 8, COL_W = 8, WAIT_W = 3;

  typedef struct {
    int    n;
    int    ras;
    bit    u, l, we, oe, cs;
    int    col;
    string tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_dram = 1'b0, req_write = 1'b0;
  logic [1:0] req_be = 2'b00;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic cfg_burst_en = 1'b0, cfg_ras_down = 1'b0, cfg_cas_ext = 1'b0;
  logic [WAIT_W-1:0] cfg_wait = '0;
  logic busy, acc_done, ras_n, ucas_n, lcas_n, we_n, oe_n, oth_cs_n;
  logic [7:0] mem_addr;

  int checks = 0, fails = 0;
  exp_t q[$];
  bit   m_open = 1'b0;
  int   m_row = 0;

  always #2 clk = ~clk;

  dram_page_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .WAIT_W(WAIT_W)) i_dram_page_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dram(req_dram),
    .req_write(req_write), .req_be(req_be), .req_addr(req_addr),
    .cfg_burst_en(cfg_burst_en), .cfg_ras_down(cfg_ras_down),
    .cfg_cas_ext(cfg_cas_ext), .cfg_wait(cfg_wait), .busy(busy),
    .acc_done(acc_done), .mem_addr(mem_addr), .ras_n(ras_n), .ucas_n(ucas_n),
    .lcas_n(lcas_n), .we_n(we_n), .oe_n(oe_n), .oth_cs_n(oth_cs_n));

  // monitor: measure each access and compare with the scoreboard head
  int  mn = 0, mlo = 0, mhi = 0, mcol = 0;
  bit  mu, ml, mw, mo, mc, mgot;
  always @(negedge clk) begin
    if (rst_n && busy) begin
      mn++;
      if (ras_n) mhi++; else mlo++;
      if (!ucas_n) mu = 1'b1;
      if (!lcas_n) ml = 1'b1;
      if (!we_n) mw = 1'b1;
      if (!oe_n) mo = 1'b1;
      if (!oth_cs_n) mc = 1'b1;
      if ((!ucas_n || !lcas_n) && !mgot) begin mcol = int'(mem_addr); mgot = 1'b1; end
      if (acc_done) begin
        int rc;
        exp_t e;
        rc = (mhi == 0) ? 0 : ((mlo == 0) ? 1 : 2);
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL unexpected access: actual n=%0d expected none", mn);
        end else begin
          e = q.pop_front();
          if (mn != e.n || rc != e.ras || mu != e.u || ml != e.l || mw != e.we ||
              mo != e.oe || mc != e.cs || mcol != e.col) begin
            fails++;
            $display("FAIL %s: actual n=%0d ras=%0d u=%0b l=%0b we=%0b oe=%0b cs=%0b col=%0d expected n=%0d ras=%0d u=%0b l=%0b we=%0b oe=%0b cs=%0b col=%0d",
                     e.tag, mn, rc, mu, ml, mw, mo, mc, mcol,
                     e.n, e.ras, e.u, e.l, e.we, e.oe, e.cs, e.col);
          end
        end
        mn = 0; mlo = 0; mhi = 0; mcol = 0;
        {mu, ml, mw, mo, mc, mgot} = '0;
      end
    end
  end

  // driver: compute the expectation from the requirements, then issue
  task automatic access(bit dram, bit wr, logic [1:0] be, int row, int col, int w, string tag);
    exp_t e;
    bit rd, hit;
    rd = cfg_burst_en && cfg_ras_down;
    e.tag = tag; e.col = 0;
    e.u = 0; e.l = 0; e.we = 0; e.oe = 0; e.cs = 0;
    if (dram) begin
      hit   = m_open && (m_row == row);
      e.n   = (hit ? 2 : 4) + int'(cfg_cas_ext) + w;
      e.ras = hit ? 0 : 2;
      e.u = be[1]; e.l = be[0]; e.we = wr; e.oe = !wr; e.col = col;
      if (cfg_burst_en) begin m_open = 1'b1; m_row = row; end
      else m_open = 1'b0;
    end else begin
      e.n   = 2 + w;
      e.ras = (m_open && rd) ? 0 : 1;
      e.cs  = 1'b1;
      if (!rd) m_open = 1'b0;
    end
    q.push_back(e);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_dram = dram; req_write = wr; req_be = be;
    req_addr = {ROW_W'(row), COL_W'(col)}; cfg_wait = WAIT_W'(w);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic go_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic main_flow();
    repeat (3) @(negedge clk);
    checks++;
    if (!(ras_n && ucas_n && lcas_n && we_n && oe_n && oth_cs_n && !busy)) begin
      fails++;
      $display("FAIL R1: actual ras=%0b u=%0b l=%0b we=%0b oe=%0b cs=%0b busy=%0b expected 1111110",
               ras_n, ucas_n, lcas_n, we_n, oe_n, oth_cs_n, busy);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R2 R6 R9 R10: no burst, full accesses
    access(1, 0, 2'b11, 1, 3, 0, "R2 full read");
    access(1, 1, 2'b01, 1, 4, 0, "R6 no-burst same row");
    go_idle(); cfg_burst_en = 1'b1;
    access(1, 0, 2'b10, 2, 5, 0, "R9 upper byte full");
    access(1, 0, 2'b11, 2, 6, 2, "R4 R3 hit with waits");
    access(1, 1, 2'b11, 3, 7, 0, "R5 miss");
    go_idle(); cfg_cas_ext = 1'b1;
    access(1, 0, 2'b01, 3, 8, 0, "R4 hit ext");
    access(1, 1, 2'b11, 7, 1, 1, "R5 R3 miss ext wait");
    go_idle(); cfg_cas_ext = 1'b0;
    access(0, 0, 2'b11, 0, 0, 1, "R8 R11 other releases row");
    access(1, 0, 2'b11, 7, 2, 0, "R8 full after other");
    go_idle(); cfg_ras_down = 1'b1;
    access(0, 1, 2'b11, 0, 0, 0, "R7 other holds row");
    access(1, 0, 2'b11, 7, 9, 0, "R7 hit after other");
    access(0, 0, 2'b11, 0, 0, 3, "R7 R11 other waits");
    access(1, 1, 2'b10, 8, 4, 0, "R5 miss after other");
    access(0, 0, 2'b11, 0, 0, 0, "R7 other again");
    access(1, 0, 2'b11, 8, 11, 1, "R7 R3 hit waits");
    go_idle(); cfg_burst_en = 1'b0; m_open = 1'b0;
    repeat (2) @(negedge clk);
    checks++;
    if (ras_n !== 1'b1) begin
      fails++;
      $display("FAIL R12: actual ras_n=%0b expected 1", ras_n);
    end
    access(1, 0, 2'b11, 8, 12, 0, "R12 full after burst off");
    access(0, 0, 2'b11, 0, 0, 0, "R12 other row closed");
    go_idle();
    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
    end
  endtask

  initial begin
    fork
      main_flow();
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule